// File: doc/BRIEF.md
# PCM Highway Time-Slot Transmitter

This block places one channel's sample on a time-division PCM highway. A frame-sync pulse, sampled on a rising bit-clock edge, marks the start of a frame. The block then counts bit periods, and when its programmed slot comes round it shifts its payload out most significant bit first. While it shifts, it raises a drive-enable output so that the highway's tri-state buffer can be switched on. Three payload formats are available. The first is a single companded byte. The second is a companded byte followed at once by a status byte, which carries the hook, auxiliary detector and fault flags. The third is a 16-bit two's-complement linear sample that spans two adjacent slots.

A half-rate option holds each data bit for two bit-clock cycles. Format, slot number, rate, channel-active flag, payload and status flags are all captured on the frame-sync edge, so they can change freely while a frame is in progress. A controller FSM has four states: ST_IDLE (no slot pending), ST_WAIT (counting bit periods toward the slot), ST_SLOT_A (first or only slot) and ST_SLOT_B (second slot). Its transitions are:

- frame sync moves the FSM from any state to ST_SLOT_A when the slot number is 0, and otherwise to ST_WAIT;
- ST_WAIT moves to ST_SLOT_A at the last bit period before the slot;
- after the eighth bit of ST_SLOT_A, the FSM moves to ST_SLOT_B in the two-slot formats and to ST_IDLE otherwise;
- after the eighth bit of ST_SLOT_B, the FSM moves to ST_IDLE.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, `txd_oe` and `txd` are 0 until a frame sync is seen.
- R2: With frame sync sampled high on edge E, bit period p of the frame starts on edge E (p = 0) and each period lasts one cycle. Slot n covers periods 8n to 8n+7 (8n to 8n+15 in the two-slot formats). `txd_oe` is high only in those periods.
- R3: Format code 2'b00 (and the spare code 2'b11) sends `sample_in[7:0]` as one slot, bit 7 first.
- R4: Format code 2'b01 sends `sample_in[7:0]` and then, with no gap, a status byte. The status byte is, from bit 7 down: `hook_in`, `aux_in`, 0, 0, 0, `fault_in`, 0, 0.
- R5: Format code 2'b10 sends `sample_in[15:0]` bit 15 first across two adjacent slots.
- R6: When `half_rate` is 1, each bit period lasts two clock cycles, and the slot timing of R2 is counted in these longer periods.
- R7: `txd` is 0 whenever `txd_oe` is 0.
- R8: With `chan_on` at 0, the data slot (the first slot, or both slots in linear format) is not driven. The status slot of format 2'b01 is still driven.
- R9: Any change on a control, payload or status input after the frame-sync edge has no effect on the frame in progress.
- R10: A frame sync that arrives while a slot is being sent abandons that slot and starts a new frame with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame-sync pulse, sampled on the rising clock edge |
| slot_sel | input | $clog2(SLOTS) | Number of the first slot owned by this channel |
| fmt | input | 2 | Payload format: 00 byte, 01 byte plus status, 10 linear, 11 as 00 |
| half_rate | input | 1 | 1 holds each bit for two clock cycles |
| chan_on | input | 1 | Channel active flag |
| sample_in | input | 16 | Companded byte in [7:0], or the linear sample |
| hook_in | input | 1 | Debounced hook status |
| aux_in | input | 1 | Second detector status |
| fault_in | input | 1 | Fault status |
| txd | output | 1 | Serial highway data |
| txd_oe | output | 1 | Highway drive enable |

## Verification
Two pairs of functions can fall in the same cycle. First, a new frame sync can coincide with a bit shift inside a slot. The bench provokes this by cutting a slot-10 frame short with a fresh frame sync for slot 1, and it judges the result by requiring that the old slot disappear and the new frame's bits appear on schedule. Second, an input change can coincide with the shifting of the captured word. The bench scrambles every input a few cycles after the sync, and its behavioural model, which holds only the values captured at the sync, must still match `txd` and `txd_oe` on every cycle.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    typedef enum logic [1:0] {
        FMT_BYTE = 2'b00,
        FMT_SIG  = 2'b01,
        FMT_LIN  = 2'b10,
        FMT_SPARE = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SLOT_A,
        ST_SLOT_B
    } tx_state_e;

    localparam int SLOT_BITS = 8;
    localparam int WORD_BITS = 16;
endpackage

// File: rtl/pcm_tx_bitclk.sv
module pcm_tx_bitclk #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             half_rate,
    output logic             adv,
    output logic [CNT_W-1:0] cnt
);
    logic run_q;
    logic phase_q;
    logic half_q;

    assign adv = run_q && (!half_q || phase_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            phase_q <= 1'b0;
            half_q  <= 1'b0;
            cnt     <= '0;
        end else if (fsync) begin
            run_q   <= 1'b1;
            phase_q <= 1'b0;
            half_q  <= half_rate;
            cnt     <= '0;
        end else if (run_q) begin
            if (adv) begin
                phase_q <= 1'b0;
                if (cnt == {CNT_W{1'b1}}) begin
                    run_q <= 1'b0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                phase_q <= 1'b1;
            end
        end
    end

    // R10: a frame sync always restarts the period count
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (cnt == '0 && run_q && !phase_q));

    // R6: in half-rate mode the count holds across the first cycle of a period
    p_half_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && run_q && half_q && !phase_q) |=> $stable(cnt));
endmodule

// File: rtl/pcm_tx_payload.sv
module pcm_tx_payload
    import pcm_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [1:0]           fmt,
    input  logic [WORD_BITS-1:0] sample_in,
    input  logic                 hook_in,
    input  logic                 aux_in,
    input  logic                 fault_in,
    output logic                 msb
);
    logic [WORD_BITS-1:0] sh_q;
    logic [SLOT_BITS-1:0] stat_byte;
    logic [WORD_BITS-1:0] load_word;

    always_comb begin
        stat_byte = {hook_in, aux_in, 3'b000, fault_in, 2'b00};
        if (fmt == FMT_LIN) begin
            load_word = sample_in;
        end else begin
            load_word = {sample_in[SLOT_BITS-1:0], stat_byte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_word;
        end else if (shift) begin
            sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_BITS-1];

    // R9: the captured word moves only on load or on a shift
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sh_q));
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
    import pcm_tx_pkg::*;
#(
    parameter int SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fsync,
    input  logic [$clog2(SLOTS)-1:0]   slot_sel,
    input  logic [1:0]                 fmt,
    input  logic                       half_rate,
    input  logic                       chan_on,
    input  logic [15:0]                sample_in,
    input  logic                       hook_in,
    input  logic                       aux_in,
    input  logic                       fault_in,
    output logic                       txd,
    output logic                       txd_oe
);
    localparam int SEL_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS * SLOT_BITS) + 1;
    localparam int BIX_W = $clog2(SLOT_BITS);

    tx_state_e        state, state_n;
    logic [BIX_W-1:0] bidx, bidx_n;
    logic [SEL_W-1:0] slot_q;
    fmt_e             fmt_q;
    logic             act_q;
    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] start_cnt;
    logic             two_slot;
    logic             in_slot;
    logic             msb;

    pcm_tx_bitclk #(.CNT_W(CNT_W)) i_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .half_rate (half_rate),
        .adv       (adv),
        .cnt       (cnt)
    );

    assign in_slot = (state == ST_SLOT_A) || (state == ST_SLOT_B);

    pcm_tx_payload i_payload (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fsync),
        .shift     (adv && in_slot && !fsync),
        .fmt       (fmt),
        .sample_in (sample_in),
        .hook_in   (hook_in),
        .aux_in    (aux_in),
        .fault_in  (fault_in),
        .msb       (msb)
    );

    assign start_cnt = CNT_W'(slot_q) << BIX_W;
    assign two_slot  = (fmt_q == FMT_SIG) || (fmt_q == FMT_LIN);

    always_comb begin
        state_n = state;
        bidx_n  = bidx;
        if (fsync) begin
            state_n = (slot_sel == '0) ? ST_SLOT_A : ST_WAIT;
            bidx_n  = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_WAIT: begin
                    if (adv && (cnt + CNT_W'(1)) == start_cnt) begin
                        state_n = ST_SLOT_A;
                    end
                end
                ST_SLOT_A: begin
                    if (adv) begin
                        bidx_n = bidx + BIX_W'(1);
                        if (bidx == {BIX_W{1'b1}}) begin
                            state_n = two_slot ? ST_SLOT_B : ST_IDLE;
                        end
                    end
                end
                ST_SLOT_B: begin
                    if (adv) begin
                        bidx_n = bidx + BIX_W'(1);
                        if (bidx == {BIX_W{1'b1}}) begin
                            state_n = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bidx   <= '0;
            slot_q <= '0;
            fmt_q  <= FMT_BYTE;
            act_q  <= 1'b0;
        end else begin
            state <= state_n;
            bidx  <= bidx_n;
            if (fsync) begin
                slot_q <= slot_sel;
                fmt_q  <= fmt_e'(fmt);
                act_q  <= chan_on;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_SLOT_A: txd_oe = act_q;
            ST_SLOT_B: txd_oe = act_q || (fmt_q == FMT_SIG);
            default:   txd_oe = 1'b0;
        endcase
        txd = txd_oe && msb;
    end

    // R3: a one-slot format leaves the slot after eight bits
    p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && state == ST_SLOT_A && adv && bidx == {BIX_W{1'b1}} && !two_slot)
        |=> state == ST_IDLE);

    // R8: the status slot is driven whatever the channel state
    p_sig_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT_B && fmt_q == FMT_SIG) |-> txd_oe);

    // R8: an inactive channel never drives its data slot
    p_idle_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT_A && !act_q) |-> !txd_oe);

    // R7: the line is low when not driven
    p_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> !txd);
endmodule

// File: tb/test_pcm_slot_tx.sv
`timescale 1ns/1ps
module test_pcm_slot_tx;
    localparam int SLOTS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [4:0]  slot_sel = '0;
    logic [1:0]  fmt = 2'b00;
    logic        half_rate = 1'b0;
    logic        chan_on = 1'b1;
    logic [15:0] sample_in = '0;
    logic        hook_in = 1'b0;
    logic        aux_in = 1'b0;
    logic        fault_in = 1'b0;
    logic        txd;
    logic        txd_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // frame captured by the model at sync
    int          m_slot;
    int          m_fmt;
    bit          m_half;
    bit          m_act;
    logic [15:0] m_word;

    always #4 clk = ~clk;

    pcm_slot_tx #(.SLOTS(SLOTS)) i_pcm_slot_tx (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_sel(slot_sel),
        .fmt(fmt), .half_rate(half_rate), .chan_on(chan_on),
        .sample_in(sample_in), .hook_in(hook_in), .aux_in(aux_in),
        .fault_in(fault_in), .txd(txd), .txd_oe(txd_oe)
    );

    task automatic chk(input string req, input int k, input logic got_oe, input logic exp_oe,
                       input logic got_d, input logic exp_d);
        checks++;
        if (got_oe !== exp_oe || got_d !== exp_d) begin
            fails++;
            $display("FAIL %s cycle %0d: oe/txd = %b%b expected %b%b", req, k, got_oe, got_d, exp_oe, exp_d);
        end
    endtask

    function automatic void model(input int k, output logic e_oe, output logic e_d, output bit owned);
        int p, off, len;
        p = m_half ? k / 2 : k;
        len = (m_fmt == 1 || m_fmt == 2) ? 16 : 8;
        off = p - 8 * m_slot;
        e_oe = 1'b0;
        e_d = 1'b0;
        owned = 1'b0;
        if (off >= 0 && off < len) begin
            owned = 1'b1;
            if (off < 8) e_oe = m_act;
            else e_oe = (m_fmt == 1) ? 1'b1 : m_act;
            e_d = e_oe ? m_word[15 - off] : 1'b0;
        end
    endfunction

    // Issue a frame and compare every cycle against the model.
    task automatic run_frame(input string req, input int slot, input int f, input bit half,
                             input bit act, input logic [15:0] data, input bit hk, input bit ax,
                             input bit ft, input int limit, input bit disturb);
        int len, ncyc;
        logic e_oe, e_d;
        bit owned;
        @(negedge clk);
        slot_sel = 5'(slot); fmt = 2'(f); half_rate = half; chan_on = act;
        sample_in = data; hook_in = hk; aux_in = ax; fault_in = ft;
        fsync = 1'b1;
        m_slot = slot; m_fmt = f; m_half = half; m_act = act;
        m_word = (f == 2) ? data : {data[7:0], hk, ax, 3'b000, ft, 2'b00};
        len = (f == 1 || f == 2) ? 16 : 8;
        ncyc = (half ? 2 : 1) * (8 * slot + len) + 6;
        if (limit > 0) ncyc = limit;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (k == 0) fsync = 1'b0;
            model(k, e_oe, e_d, owned);
            chk(owned ? req : "R7", k, txd_oe, e_oe, txd, e_d);
            if (disturb && k == 2) begin
                // R9: scramble everything after capture
                slot_sel = ~slot_sel; fmt = ~fmt; half_rate = ~half_rate; chan_on = ~chan_on;
                sample_in = ~sample_in; hook_in = ~hook_in; aux_in = ~aux_in; fault_in = ~fault_in;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 0, txd_oe, 1'b0, txd, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R1", i, txd_oe, 1'b0, txd, 1'b0);
        end
        // R2: slot position, slot 0 and a later slot
        run_frame("R2", 0, 0, 1'b0, 1'b1, 16'h00A5, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_frame("R2", 5, 0, 1'b0, 1'b1, 16'h00C3, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        // R3: byte format, and the spare code acting as byte
        run_frame("R3", 1, 0, 1'b0, 1'b1, 16'hFF81, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        run_frame("R3", 2, 3, 1'b0, 1'b1, 16'h1276, 1'b1, 1'b0, 1'b1, 0, 1'b0);
        // R4: byte followed by status
        run_frame("R4", 3, 1, 1'b0, 1'b1, 16'h005C, 1'b1, 1'b0, 1'b1, 0, 1'b0);
        run_frame("R4", 30, 1, 1'b0, 1'b1, 16'h00E1, 1'b0, 1'b1, 1'b0, 0, 1'b0);
        // R5: linear sample across two slots
        run_frame("R5", 7, 2, 1'b0, 1'b1, 16'h8A53, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_frame("R5", 0, 2, 1'b0, 1'b1, 16'h7FFE, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        // R6: half-rate in each format
        run_frame("R6", 2, 0, 1'b1, 1'b1, 16'h0069, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_frame("R6", 1, 1, 1'b1, 1'b1, 16'h0096, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        run_frame("R6", 4, 2, 1'b1, 1'b1, 16'hB00D, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        // R8: inactive channel
        run_frame("R8", 4, 1, 1'b0, 1'b0, 16'h00FF, 1'b1, 1'b0, 1'b1, 0, 1'b0);
        run_frame("R8", 1, 0, 1'b0, 1'b0, 16'h00FF, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run_frame("R8", 2, 2, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        // R9: inputs change mid-frame
        run_frame("R9", 6, 1, 1'b0, 1'b1, 16'h003A, 1'b1, 1'b0, 1'b0, 0, 1'b1);
        run_frame("R9", 3, 2, 1'b1, 1'b1, 16'h4C21, 1'b0, 1'b1, 1'b1, 0, 1'b1);
        // R10: sync arrives mid-slot, then a fresh frame
        run_frame("R10", 10, 2, 1'b0, 1'b1, 16'hFFFF, 1'b0, 0, 0, 84, 1'b0);
        run_frame("R10", 1, 0, 1'b0, 1'b1, 16'h0055, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule